// File: doc/BRIEF.md
# Power-Button Event and Long-Press Shutdown Controller

This block watches a debounced power-button level and a supply-present level, and keeps track of the device power state: no supply, off, sleep or active. It records three latched interrupt events: supply connected, button pressed, and button held for a long press. The host clears each event by writing a one to its bit on the acknowledge port. It can hide any event from the combined interrupt line with a mask. A press while the device is off or asleep produces a wake request and moves the tracked state to active.

A long press opens an acknowledge window. If the host does not acknowledge the long-press event before the window runs out, the block emits a one-cycle power-down request and moves the tracked state to off. All timing counts strobes on a 1 ms tick input. The hold time (6000 ticks by default) and the window (2000 ticks by default) are parameters, so a simulation can shorten them. The tracked state is visible on an output so that the surrounding logic can sequence regulators from it.

Top module: `pwrkey_evt_ctrl`

## Requirements
- R1: While the state is no-supply (code 0), a high `supply_ok_i` sets status bit 0 (supply connected) at the next clock edge, and the state moves to off (code 1).
- R2: A rising level on `btn_i`, seen while supply is present and the state is not no-supply, sets status bit 1 (button pressed) at that clock edge.
- R3: A press while the state is off (1) or sleep (2) gives a one-cycle `wake_o` pulse in the cycle after the edge, and the state becomes active (3). A press while the state is active gives no wake pulse.
- R4: With the button held, the LONG_PRESS_TICKS-th tick after the press sets status bit 2 (long press) at that edge. Releasing the button restarts the count on the next press, and a single press raises at most one long-press event.
- R5: If status bit 2 is not acknowledged within ACK_WINDOW_TICKS ticks of being set, `pwrdn_o` is high for exactly one cycle, and the state reads off (1) in that same cycle.
- R6: Writing `ack_i[2]` during the window cancels the pending power-down. Releasing the button does not cancel it.
- R7: The status bits are write-one-to-clear through `ack_i`. An event that arrives in the same cycle as the acknowledge of its bit leaves the bit set.
- R8: `irq_o` is high exactly when some status bit is set and its `mask_i` bit (1 = masked) is low.
- R9: A low `supply_ok_i` moves the state to no-supply (0) at the next edge. While the state is no-supply, button activity sets no status bit and gives no wake pulse.
- R10: A high `sleep_req_i` while the state is active moves the state to sleep (2) at the next edge.
- R11: After reset the status bits are 0, the state is no-supply, and `irq_o`, `wake_o` and `pwrdn_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe every 1 ms |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| supply_ok_i | input | 1 | Main supply present |
| sleep_req_i | input | 1 | Request to move from active to sleep |
| ack_i | input | 3 | Write-one-to-clear for the status bits |
| mask_i | input | 3 | Interrupt mask, 1 = hidden from irq_o |
| status_o | output | 3 | Latched events: bit0 supply, bit1 press, bit2 long press |
| irq_o | output | 1 | Combined interrupt, active high |
| wake_o | output | 1 | One-cycle wake request |
| pwrdn_o | output | 1 | One-cycle power-down request |
| state_o | output | 2 | Tracked power state: 0 no-supply, 1 off, 2 sleep, 3 active |

## Verification
The main sequence is driven through several hold patterns. A hold just one tick short of the threshold must not fire the event, while a hold that reaches it must. A release followed by a re-press must restart the count. A hold that goes far past the threshold must yield a single event. The window is tried three ways: acknowledged on its last tick while still held, released and left unacknowledged, and acknowledged right after the event. These separate a correct cancel from a release-based cancel and from an off-by-one expiry. A table walks every mask value over a full status word, which exposes a bit that is wrongly ORed or wrongly inverted. Presses while active, off, asleep and unpowered show that wake pulses depend on the state.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
   typedef enum logic [1:0] {
      PS_NOSUP  = 2'd0,
      PS_OFF    = 2'd1,
      PS_SLEEP  = 2'd2,
      PS_ACTIVE = 2'd3
   } pwr_state_e;

   localparam int unsigned EVT_N     = 3;
   localparam int unsigned IDX_SUP   = 0;
   localparam int unsigned IDX_PRESS = 1;
   localparam int unsigned IDX_LONG  = 2;
endpackage

// File: rtl/pwrkey_hold_timer.sv
// Detects the press edge and counts ticks while the button stays down.
module pwrkey_hold_timer #(
   parameter int unsigned HOLD_TICKS = 6000,
   parameter int unsigned CW         = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic btn_i,
   input  logic tick_i,
   output logic press_o,
   output logic long_o
);
   logic          btn_q;
   logic          fired_q;
   logic [CW-1:0] cnt_q;
   logic          at_limit;

   assign press_o  = en_i & btn_i & ~btn_q;
   assign at_limit = (cnt_q == CW'(HOLD_TICKS - 1));
   assign long_o   = en_i & btn_i & ~press_o & tick_i & ~fired_q & at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btn_q   <= 1'b0;
         fired_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         btn_q <= btn_i;
         if (!en_i || !btn_i || press_o) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else if (tick_i && !fired_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (at_limit) fired_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwrkey_ack_window.sv
// Counts the acknowledge window after a long press and flags its expiry.
module pwrkey_ack_window #(
   parameter int unsigned WIN_TICKS = 2000,
   parameter int unsigned CW        = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic ack_i,
   input  logic abort_i,
   input  logic tick_i,
   output logic expire_o
);
   logic          pend_q;
   logic [CW-1:0] cnt_q;

   assign expire_o = pend_q & tick_i & ~ack_i & ~abort_i
                   & (cnt_q == CW'(WIN_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (arm_i) begin
         pend_q <= 1'b1;
         cnt_q  <= '0;
      end else if (ack_i || abort_i || expire_o) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (pend_q && tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwrkey_irq_regs.sv
// Write-one-to-clear event latches with a masked OR.
module pwrkey_irq_regs #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] ack_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] status_o,
   output logic         irq_o
);
   logic [N-1:0] stat_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        stat_q[i] <= 1'b0;
         else if (set_i[i]) stat_q[i] <= 1'b1;
         else if (ack_i[i]) stat_q[i] <= 1'b0;
      end
   end

   assign status_o = stat_q;
   assign irq_o    = |(stat_q & ~mask_i);
endmodule

// File: rtl/pwrkey_pwr_fsm.sv
// Tracks the device power state and issues wake and power-down pulses.
module pwrkey_pwr_fsm
   import pwrkey_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_i,
   input  logic       press_i,
   input  logic       expire_i,
   input  logic       sleep_req_i,
   output pwr_state_e state_o,
   output logic       connect_o,
   output logic       powered_o,
   output logic       wake_o,
   output logic       pwrdn_o
);
   pwr_state_e st_q, st_d;
   logic       wake_q, pwrdn_q, wake_d;

   assign connect_o = supply_i & (st_q == PS_NOSUP);
   assign powered_o = supply_i & (st_q != PS_NOSUP);
   assign wake_d    = powered_o & press_i & ~expire_i
                    & ((st_q == PS_OFF) | (st_q == PS_SLEEP));

   always_comb begin
      st_d = st_q;
      if (!supply_i)                             st_d = PS_NOSUP;
      else if (st_q == PS_NOSUP)                 st_d = PS_OFF;
      else if (expire_i)                         st_d = PS_OFF;
      else if (wake_d)                           st_d = PS_ACTIVE;
      else if (st_q == PS_ACTIVE && sleep_req_i) st_d = PS_SLEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_NOSUP;
         wake_q  <= 1'b0;
         pwrdn_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         wake_q  <= wake_d;
         pwrdn_q <= expire_i & powered_o;
      end
   end

   assign state_o = st_q;
   assign wake_o  = wake_q;
   assign pwrdn_o = pwrdn_q;
endmodule

// File: rtl/pwrkey_evt_ctrl.sv
module pwrkey_evt_ctrl
   import pwrkey_pkg::*;
#(
   parameter int unsigned LONG_PRESS_TICKS = 6000,
   parameter int unsigned ACK_WINDOW_TICKS = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       btn_i,
   input  logic       supply_ok_i,
   input  logic       sleep_req_i,
   input  logic [2:0] ack_i,
   input  logic [2:0] mask_i,
   output logic [2:0] status_o,
   output logic       irq_o,
   output logic       wake_o,
   output logic       pwrdn_o,
   output logic [1:0] state_o
);
   localparam int unsigned HOLD_CW = $clog2(LONG_PRESS_TICKS + 1);
   localparam int unsigned WIN_CW  = $clog2(ACK_WINDOW_TICKS + 1);

   if (LONG_PRESS_TICKS < 2) begin : g_chk_hold
      $error("LONG_PRESS_TICKS must be at least 2");
   end
   if (ACK_WINDOW_TICKS < 2) begin : g_chk_win
      $error("ACK_WINDOW_TICKS must be at least 2");
   end

   logic       press, long_evt, expire, connect, powered;
   pwr_state_e st;
   logic [EVT_N-1:0] evt_set;

   pwrkey_hold_timer #(.HOLD_TICKS(LONG_PRESS_TICKS), .CW(HOLD_CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .en_i(powered), .btn_i(btn_i),
      .tick_i(tick_i), .press_o(press), .long_o(long_evt)
   );

   pwrkey_ack_window #(.WIN_TICKS(ACK_WINDOW_TICKS), .CW(WIN_CW)) u_win (
      .clk(clk), .rst_n(rst_n), .arm_i(long_evt), .ack_i(ack_i[IDX_LONG]),
      .abort_i(~powered), .tick_i(tick_i), .expire_o(expire)
   );

   pwrkey_pwr_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .supply_i(supply_ok_i), .press_i(press),
      .expire_i(expire), .sleep_req_i(sleep_req_i), .state_o(st),
      .connect_o(connect), .powered_o(powered), .wake_o(wake_o),
      .pwrdn_o(pwrdn_o)
   );

   assign evt_set[IDX_SUP]   = connect;
   assign evt_set[IDX_PRESS] = press;
   assign evt_set[IDX_LONG]  = long_evt;

   pwrkey_irq_regs #(.N(EVT_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .set_i(evt_set), .ack_i(ack_i),
      .mask_i(mask_i), .status_o(status_o), .irq_o(irq_o)
   );

   assign state_o = st;
endmodule

// File: rtl/pwrkey_evt_ctrl_chk.sv
module pwrkey_evt_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       btn_i,
   input logic       supply_ok_i,
   input logic [2:0] ack_i,
   input logic [2:0] status_o,
   input logic       wake_o,
   input logic       pwrdn_o,
   input logic [1:0] state_o
);
   p_pwrdn_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_o |=> !pwrdn_o);
   p_pwrdn_to_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_o |-> (state_o == 2'd1));
   p_wake_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (state_o == 2'd3));
   p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);
   p_press_needs_btn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[1]) |-> $past(btn_i));
   p_long_needs_btn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[2]) |-> $past(btn_i));
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[1] && !btn_i) |=> !status_o[1]);
   p_supply_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_i |=> (state_o == 2'd0));
   p_no_wake_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0) |=> !wake_o);
endmodule

bind pwrkey_evt_ctrl pwrkey_evt_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .supply_ok_i(supply_ok_i),
   .ack_i(ack_i), .status_o(status_o), .wake_o(wake_o),
   .pwrdn_o(pwrdn_o), .state_o(state_o)
);

// File: tb/tb_pwrkey_evt_ctrl.sv
module tb_pwrkey_evt_ctrl;
   localparam int CLK_P = 10;
   localparam int LP    = 6;
   localparam int AW    = 4;

   // Mask walk: {mask, expected irq} with all three status bits set (R8)
   localparam logic [3:0] MASK_TBL [8] = '{
      4'b000_1, 4'b001_1, 4'b010_1, 4'b011_1,
      4'b100_1, 4'b101_1, 4'b110_1, 4'b111_0
   };

   logic clk = 0, rst_n = 0, tick_i = 0, btn_i = 0, supply_ok_i = 0, sleep_req_i = 0;
   logic [2:0] ack_i = 0, mask_i = 0;
   logic [2:0] status_o;
   logic irq_o, wake_o, pwrdn_o;
   logic [1:0] state_o;
   int n_chk = 0, n_err = 0, n_pd = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   pwrkey_evt_ctrl #(.LONG_PRESS_TICKS(LP), .ACK_WINDOW_TICKS(AW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .btn_i(btn_i),
      .supply_ok_i(supply_ok_i), .sleep_req_i(sleep_req_i), .ack_i(ack_i),
      .mask_i(mask_i), .status_o(status_o), .irq_o(irq_o), .wake_o(wake_o),
      .pwrdn_o(pwrdn_o), .state_o(state_o)
   );

   always @(negedge clk) if (pwrdn_o) n_pd++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic tick();
      tick_i = 1; cyc(); tick_i = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic ack(input logic [2:0] v);
      ack_i = v; cyc(); ack_i = 0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      cyc(); cyc();
      chk(status_o == 0, "R11 status", status_o, 0);
      chk(state_o == 0, "R11 state", state_o, 0);
      chk(!irq_o && !wake_o && !pwrdn_o, "R11 outputs", {irq_o, wake_o, pwrdn_o}, 0);
      rst_n = 1; cyc();

      // R9: button ignored without supply
      btn_i = 1; cyc(); cyc();
      chk(status_o == 0, "R9 press unpowered", status_o, 0);
      chk(!wake_o, "R9 no wake", wake_o, 0);
      btn_i = 0; cyc();

      // R1
      supply_ok_i = 1; cyc();
      chk(status_o == 3'b001, "R1 connect bit", status_o, 1);
      chk(state_o == 1, "R1 state off", state_o, 1);
      chk(irq_o, "R8 irq unmasked", irq_o, 1);
      ack(3'b001);
      chk(status_o == 0, "R7 w1c", status_o, 0);

      // R2 R3 press in off
      btn_i = 1; cyc();
      chk(status_o[1], "R2 press bit", status_o, 2);
      chk(wake_o, "R3 wake off", wake_o, 1);
      chk(state_o == 3, "R3 active", state_o, 3);
      cyc();
      chk(!wake_o, "R3 wake one cycle", wake_o, 0);

      // R4 threshold, R6 ack on last window tick cancels
      ticks(LP - 1);
      chk(!status_o[2], "R4 one short", status_o, 0);
      tick();
      chk(status_o[2], "R4 long bit", status_o, 4);
      ticks(AW - 1);
      ack(3'b100);
      btn_i = 0; cyc();
      ticks(AW + 2); cyc();
      chk(n_pd == 0, "R6 ack cancels", n_pd, 0);
      chk(state_o == 3, "R6 still active", state_o, 3);
      ack(3'b111);

      // R3 press while active: no wake
      btn_i = 1; cyc();
      chk(!wake_o, "R3 no wake active", wake_o, 0);
      // R5 expiry after release
      ticks(LP);
      chk(status_o[2], "R4 long again", status_o, 6);
      btn_i = 0; cyc();
      ticks(AW - 1);
      chk(n_pd == 0 && state_o == 3, "R6 release no cancel", n_pd, 0);
      tick();
      chk(pwrdn_o, "R5 pwrdn pulse", pwrdn_o, 1);
      chk(state_o == 1, "R5 state off", state_o, 1);
      cyc();
      chk(!pwrdn_o && n_pd == 1, "R5 single pulse", n_pd, 1);
      ack(3'b111);

      // R4 one event per press
      btn_i = 1; cyc();
      chk(wake_o, "R3 wake after pwrdn", wake_o, 1);
      ticks(LP);
      ack(3'b100);
      ticks(LP + 2);
      chk(!status_o[2], "R4 single event", status_o, 0);
      btn_i = 0; cyc();
      // R4 restart after release
      btn_i = 1; cyc(); ticks(LP - 1);
      btn_i = 0; cyc();
      btn_i = 1; cyc(); ticks(LP - 1);
      chk(!status_o[2], "R4 restart count", status_o, 0);
      tick();
      chk(status_o[2], "R4 after restart", status_o, 4);
      ack(3'b100);
      btn_i = 0; cyc();
      ack(3'b111);

      // R7 set wins over ack
      btn_i = 1; ack_i = 3'b010; cyc(); ack_i = 0;
      chk(status_o[1], "R7 set wins", status_o, 2);
      btn_i = 0;
      // R10 sleep
      sleep_req_i = 1; cyc(); sleep_req_i = 0;
      chk(state_o == 2, "R10 sleep", state_o, 2);
      btn_i = 1; cyc();
      chk(wake_o && state_o == 3, "R3 wake sleep", state_o, 3);
      btn_i = 0; cyc();

      // R9 supply loss, then R8 mask walk
      supply_ok_i = 0; cyc();
      chk(state_o == 0, "R9 nosup", state_o, 0);
      supply_ok_i = 1; cyc();
      chk(status_o[0], "R1 reconnect", status_o, 1);
      btn_i = 1; cyc(); ticks(LP);
      chk(status_o == 3'b111, "R8 all set", status_o, 7);
      foreach (MASK_TBL[i]) begin
         mask_i = MASK_TBL[i][3:1]; #1;
         chk(irq_o == MASK_TBL[i][0], "R8 mask walk", irq_o, MASK_TBL[i][0]);
      end
      mask_i = 0;
      ack(3'b111);
      btn_i = 0; cyc();
      ticks(AW + 1);
      chk(n_pd == 1, "R6 acked no pwrdn", n_pd, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule